// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Tracker

This unit sits beside one core's load/store path and implements the bookkeeping behind a load-reserved / store-conditional pair. A load-reserved request reads memory and arms a reservation on the accessed line. A later store-conditional is forwarded to memory as a write only while that reservation is still armed and covers the store's line. The store-conditional response is a status word: zero means the store took place, one means it was dropped.

Reservations are lost in several ways. A coherence invalidation that reaches this core kills the reservation, and so does any store-conditional issued by this core, whether it succeeds or not. When a store-conditional succeeds, the unit sends a one-cycle kill notice carrying the written address, so the trackers of the other cores can drop their own reservations on that line. The parameter `TRACK_ADDR` selects one of two variants. The address-tracking variant stores the reserved line and compares addresses. The address-less variant stores only the flag, so any invalidation kills the reservation and a store-conditional needs only the flag.

Top module: `lrsc_tracker`

## Requirements
- R1: A load-reserved request (`req_valid`=1, `req_sc`=0) raises `mem_rd_en` in the same cycle. One cycle later `rsp_valid` is 1 and `rsp_data` carries the memory word at `req_addr`. The next cycle `resv_active` is 1, unless R10 applies.
- R2: In address-tracking mode, a store-conditional succeeds when `resv_active` is 1 and the store's line equals the reserved line. On success, `mem_wr_en` is 1 in the request cycle with `mem_addr`=`req_addr` and `mem_wdata`=`req_wdata`, and the response one cycle later is `rsp_data`=0.
- R3: A store-conditional that fails leaves `mem_wr_en` at 0 and changes no memory word. Its response one cycle later is `rsp_data`=1, with every bit above bit 0 at zero.
- R4: After any store-conditional, whether it succeeds or fails, `resv_active` is 0 in the next cycle.
- R5: A successful store-conditional raises `kill_valid` in the same cycle, with `kill_addr`=`req_addr`. `kill_valid` stays 0 at all other times.
- R6: In address-tracking mode, an invalidation (`inv_valid`=1) whose line matches the reserved line clears `resv_active` in the next cycle. An invalidation to any other line leaves the reservation in place.
- R7: In address-less mode, any invalidation clears the reservation, and a store-conditional succeeds whenever the flag is set, whatever its address.
- R8: An invalidation that hits the reservation in the same cycle as a store-conditional makes that store-conditional fail.
- R9: A new load-reserved replaces any earlier reservation. Only the most recent line counts.
- R10: A load-reserved that arrives in the same cycle as an invalidation hitting its own line leaves `resv_active` at 0. In address-less mode, any invalidation in that cycle has this effect.
- R11: While `rst_n` is low, `rsp_valid` and `resv_active` are 0. `rst_n` takes effect asynchronously but is released through a synchronizer.
- R12: Addresses are compared per line. The low `LINE_OFS` address bits are ignored in both the store-conditional match and the invalidation match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present this cycle |
| req_sc | input | 1 | 1 = store-conditional, 0 = load-reserved |
| req_addr | input | ADDR_W | Request word address |
| req_wdata | input | DATA_W | Store-conditional data |
| rsp_valid | output | 1 | Response present, one cycle after request |
| rsp_data | output | DATA_W | Read data, or status for store-conditional (0 ok, 1 fail) |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after `mem_rd_en` |
| inv_valid | input | 1 | Coherence invalidation present |
| inv_addr | input | ADDR_W | Invalidated address |
| kill_valid | output | 1 | Notice to other cores: reserved line written |
| kill_addr | output | ADDR_W | Address written by the successful store-conditional |
| resv_active | output | 1 | Reservation flag |

## Verification
An invalidation can arrive in the same cycle as a store-conditional, and in the same cycle as a load-reserved. The sweep provokes both cases by raising `inv_valid` at the reserved address together with the request. The same sweep also raises invalidations on their own cycle, to the reserved line or to a different line. Two instances run the same stimulus, one per address mode. Each result is judged against a per-mode reference model: `mem_wr_en`/`kill_valid` are checked in the request cycle, and the status word and `resv_active` one cycle later. Each store is followed by a load-reserved read-back, which confirms whether memory changed.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  typedef enum logic {
    OP_LR = 1'b0,
    OP_SC = 1'b1
  } lrsc_op_e;
endpackage

// File: rtl/lrsc_rst_sync.sv
module lrsc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/lrsc_resv_state.sv
module lrsc_resv_state
  import lrsc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_OFS   = 2,
  parameter bit TRACK_ADDR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  lrsc_op_e          req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              flag,
  output logic              sc_pass
);
  localparam int LINE_W = ADDR_W - LINE_OFS;

  logic flag_q, flag_d;
  logic req_match;
  logic inv_hit_cur;
  logic inv_hit_new;
  logic lr_take;
  logic sc_take;

  assign lr_take = req_valid && (req_op == OP_LR);
  assign sc_take = req_valid && (req_op == OP_SC);

  generate
    if (TRACK_ADDR) begin : g_track
      logic [LINE_W-1:0] line_q, line_d;
      logic              line_en;

      assign line_en = lr_take;

      always_comb begin
        line_d = line_q;
        if (line_en) begin
          line_d = req_addr[ADDR_W-1:LINE_OFS];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          line_q <= '0;
        end else begin
          line_q <= line_d;
        end
      end

      assign req_match   = (req_addr[ADDR_W-1:LINE_OFS] == line_q);
      assign inv_hit_cur = inv_valid && (inv_addr[ADDR_W-1:LINE_OFS] == line_q);
      assign inv_hit_new = inv_valid &&
                           (inv_addr[ADDR_W-1:LINE_OFS] == req_addr[ADDR_W-1:LINE_OFS]);
    end else begin : g_noaddr
      assign req_match   = 1'b1;
      assign inv_hit_cur = inv_valid;
      assign inv_hit_new = inv_valid;
    end
  endgenerate

  assign sc_pass = sc_take && flag_q && req_match && !inv_hit_cur;

  always_comb begin
    flag_d = flag_q;
    if (lr_take) begin
      flag_d = !inv_hit_new;
    end else if (sc_take) begin
      flag_d = 1'b0;
    end else if (inv_hit_cur) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  assert_sc_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sc_take |=> !flag_q);
  assert_inv_kills_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && inv_hit_cur) |=> !flag_q);
  assert_lr_arms_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_take && !inv_hit_new) |=> flag_q);
  assert_lr_inv_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_take && inv_hit_new) |=> !flag_q);
endmodule

// File: rtl/lrsc_resp.sv
module lrsc_resp
  import lrsc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  lrsc_op_e          req_op,
  input  logic              sc_pass,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  logic vld_q, vld_d;
  logic is_sc_q, is_sc_d;
  logic fail_q, fail_d;

  always_comb begin
    vld_d   = req_valid;
    is_sc_d = is_sc_q;
    fail_d  = fail_q;
    if (req_valid) begin
      is_sc_d = (req_op == OP_SC);
      fail_d  = !sc_pass;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      is_sc_q <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      vld_q   <= vld_d;
      is_sc_q <= is_sc_d;
      fail_q  <= fail_d;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_data  = is_sc_q ? {{(DATA_W-1){1'b0}}, fail_q} : mem_rdata;

  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid));
endmodule

// File: rtl/lrsc_tracker.sv
module lrsc_tracker
  import lrsc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_OFS   = 2,
  parameter bit TRACK_ADDR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_sc,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              kill_valid,
  output logic [ADDR_W-1:0] kill_addr,
  output logic              resv_active
);
  logic     rst_n_s;
  lrsc_op_e op;
  logic     sc_pass;

  assign op = req_sc ? OP_SC : OP_LR;

  lrsc_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .arst_n    (rst_n),
    .rst_n_sync(rst_n_s)
  );

  lrsc_resv_state #(
    .ADDR_W    (ADDR_W),
    .LINE_OFS  (LINE_OFS),
    .TRACK_ADDR(TRACK_ADDR)
  ) u_state (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .req_valid(req_valid),
    .req_op   (op),
    .req_addr (req_addr),
    .inv_valid(inv_valid),
    .inv_addr (inv_addr),
    .flag     (resv_active),
    .sc_pass  (sc_pass)
  );

  lrsc_resp #(.DATA_W(DATA_W)) u_resp (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .req_valid(req_valid),
    .req_op   (op),
    .sc_pass  (sc_pass),
    .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data)
  );

  assign mem_rd_en  = req_valid && !req_sc;
  assign mem_wr_en  = sc_pass;
  assign mem_addr   = req_addr;
  assign mem_wdata  = req_wdata;
  assign kill_valid = sc_pass;
  assign kill_addr  = req_addr;

  assert_nowrite_unarmed_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && req_sc && !resv_active) |-> !mem_wr_en);
  assert_kill_drops_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    kill_valid |=> !resv_active);
  assert_write_armed_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_wr_en |-> (resv_active && req_valid && req_sc));

  generate
    if (!TRACK_ADDR) begin : g_noaddr_chk
      assert_any_inv_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
        (inv_valid && !req_valid) |=> !resv_active);
      assert_inv_beats_sc_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
        inv_valid |-> !mem_wr_en);
    end
  endgenerate
endmodule

// File: tb/lrsc_tracker_tb_top.sv
module lrsc_tracker_tb_top;
  localparam int AW  = 4;
  localparam int DW  = 8;
  localparam int OFS = 1;
  localparam int NW  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid, req_sc, inv_valid;
  logic [AW-1:0] req_addr, inv_addr;
  logic [DW-1:0] req_wdata;

  logic [1:0]    rsp_valid, rd_en, wr_en, kill_valid, resv;
  logic [DW-1:0] rsp_data [2];
  logic [AW-1:0] maddr [2];
  logic [AW-1:0] kaddr [2];
  logic [DW-1:0] mwdata [2];
  logic [DW-1:0] mrdata [2];
  logic [DW-1:0] mem [2][NW];

  int vectors = 0;
  int fails = 0;
  int cycles = 0;

  logic          mf [2];
  logic [AW-1:0] ma [2];
  logic [DW-1:0] mm [2][NW];

  lrsc_tracker #(.ADDR_W(AW), .DATA_W(DW), .LINE_OFS(OFS), .TRACK_ADDR(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sc(req_sc),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid[0]),
    .rsp_data(rsp_data[0]), .mem_rd_en(rd_en[0]), .mem_wr_en(wr_en[0]),
    .mem_addr(maddr[0]), .mem_wdata(mwdata[0]), .mem_rdata(mrdata[0]),
    .inv_valid(inv_valid), .inv_addr(inv_addr), .kill_valid(kill_valid[0]),
    .kill_addr(kaddr[0]), .resv_active(resv[0]));

  lrsc_tracker #(.ADDR_W(AW), .DATA_W(DW), .LINE_OFS(OFS), .TRACK_ADDR(1'b0)) dut_nt_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sc(req_sc),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid[1]),
    .rsp_data(rsp_data[1]), .mem_rd_en(rd_en[1]), .mem_wr_en(wr_en[1]),
    .mem_addr(maddr[1]), .mem_wdata(mwdata[1]), .mem_rdata(mrdata[1]),
    .inv_valid(inv_valid), .inv_addr(inv_addr), .kill_valid(kill_valid[1]),
    .kill_addr(kaddr[1]), .resv_active(resv[1]));

  always @(posedge clk) begin
    for (int m = 0; m < 2; m++) begin
      if (wr_en[m]) mem[m][maddr[m]] <= mwdata[m];
      if (rd_en[m]) mrdata[m] <= mem[m][maddr[m]];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // op: 0 idle, 1 load-reserved, 2 store-conditional
  task automatic step(input int op, input int a, input int wd, input bit iv, input int ia);
    bit          ok [2];
    logic        nf [2];
    logic [DW-1:0] old [2];
    @(negedge clk);
    req_valid = (op != 0);
    req_sc    = (op == 2);
    req_addr  = AW'(a);
    req_wdata = DW'(wd);
    inv_valid = iv;
    inv_addr  = AW'(ia);
    #1;
    for (int m = 0; m < 2; m++) begin
      bit hit_cur, hit_new, match;
      hit_cur = iv && (m == 1 || ((ia >> OFS) == (int'(ma[m]) >> OFS)));
      hit_new = iv && (m == 1 || ((ia >> OFS) == (a >> OFS)));
      match   = (m == 1) || ((a >> OFS) == (int'(ma[m]) >> OFS));
      ok[m]   = (op == 2) && mf[m] && match && !hit_cur;
      old[m]  = mm[m][a];
      if (op == 1)      begin nf[m] = !hit_new; ma[m] = AW'(a); end
      else if (op == 2) nf[m] = 1'b0;
      else              nf[m] = mf[m] && !hit_cur;
      chk(wr_en[m] == ok[m], $sformatf("R2/R3/R7/R8/R12 mem_wr_en m%0d", m), wr_en[m], ok[m]);
      chk(kill_valid[m] == ok[m], $sformatf("R5 kill_valid m%0d", m), kill_valid[m], ok[m]);
      if (ok[m]) begin
        chk(kaddr[m] == AW'(a), "R5 kill_addr", kaddr[m], a);
        chk(mwdata[m] == DW'(wd) && maddr[m] == AW'(a), "R2 write data/addr", mwdata[m], wd);
        mm[m][a] = DW'(wd);
      end
      chk(rd_en[m] == (op == 1), "R1 mem_rd_en", rd_en[m], (op == 1));
    end
    @(posedge clk);
    #1;
    for (int m = 0; m < 2; m++) begin
      chk(rsp_valid[m] == (op != 0), "R1 rsp_valid", rsp_valid[m], (op != 0));
      if (op == 1) chk(rsp_data[m] == old[m], "R1/R3 read data", rsp_data[m], old[m]);
      if (op == 2) chk(rsp_data[m] == (ok[m] ? 0 : 1), "R2/R3 status", rsp_data[m], ok[m] ? 0 : 1);
      chk(resv[m] == nf[m], $sformatf("R4/R6/R7/R9/R10 resv_active m%0d", m), resv[m], nf[m]);
      mf[m] = nf[m];
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  initial begin
    req_valid = 0; req_sc = 0; req_addr = '0; req_wdata = '0;
    inv_valid = 0; inv_addr = '0;
    for (int m = 0; m < 2; m++) begin
      mf[m] = 1'b0;
      ma[m] = '0;
      for (int i = 0; i < NW; i++) begin
        mem[m][i] = DW'(i * 3 + 1);
        mm[m][i]  = DW'(i * 3 + 1);
      end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      chk(rsp_valid[m] == 1'b0, "R11 rsp_valid in reset", rsp_valid[m], 0);
      chk(resv[m] == 1'b0, "R11 resv_active in reset", resv[m], 0);
    end
    rst_n = 1'b1;
    repeat (5) @(posedge clk);

    // R9: later load-reserved replaces earlier one
    step(1, 2, 0, 0, 0);
    step(1, 9, 0, 0, 0);
    step(2, 2, 8'hA5, 0, 0);
    // R10: load-reserved with same-line invalidation stays unarmed
    step(1, 6, 0, 1, 7);
    step(2, 6, 8'h5A, 0, 0);
    // R10 in address mode only: invalidation elsewhere
    step(1, 6, 0, 1, 12);
    step(2, 7, 8'h3C, 0, 0);

    for (int a = 0; a < NW; a++) begin
      for (int s = 0; s < NW; s++) begin
        for (int k = 0; k < 4; k++) begin
          int wd;
          wd = (a * 16 + s * 5 + k * 7 + 1) & 8'hFF;
          step(1, a, 0, 0, 0);
          if (k == 1) step(0, 0, 0, 1, a ^ 1);        // R6 same line
          if (k == 2) step(0, 0, 0, 1, a ^ 4);        // R6/R7 other line
          step(2, s, wd, (k == 3), a);                 // R8 when k==3
          if (k == 0) step(2, s, wd ^ 8'hFF, 0, 0);    // R4 second SC fails
          step(1, s, 0, 0, 0);                         // read-back
        end
      end
    end

    step(0, 0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule